// File: doc/BRIEF.md
# Programmable Stage-Select Divider Timer

This block is a synchronous timer built on a binary counter that advances on rising clock edges while a count-enable strobe is high. Two select pins pick one of four counter stages as the timing tap. A mode pin picks what the output does with that tap. In recycle mode the output is a continuous square wave. In single-transition mode the output is a one-shot delay: it rises once and stays high.

A polarity pin picks the true or the inverted output. An active-high synchronous master reset clears the timing. The power-on reset is an active-low pulse input. A disable pin decides whether that pulse starts timing at once, or whether counting waits for a master reset pulse.

The tap stage numbers are parameters. The defaults give a 16-stage counter with taps at stages 13, 10, 8 and 16.

Top module: `stage_timer`

## Requirements
- R1: The counter advances by one on each rising edge where cntEn is high, running is permitted and no reset is active. On every other edge it holds its value, including across wraparound at 2^CNT_W.
- R2: {selA, selB} picks the tap stage N, and stage N is counter bit N-1. The pairs map as follows: 00 gives N=13 (TAP_LL), 01 gives N=10 (TAP_LH), 10 gives N=8 (TAP_HL), 11 gives N=16 (TAP_HH).
- R3: With recycle=1 the true output equals counter bit N-1. This is a square wave with a period of 2^N enabled counts.
- R4: With recycle=0, after a reset the true output is low until the count reaches 2^(N-1). It then goes high and stays high, even when the counter wraps around.
- R5: Raising recycle to 1 clears the single-transition latch. A later return to recycle=0 starts from an unlatched state.
- R6: polInv=1 inverts the output, so after a reset the output equals polInv.
- R7: While masterRst is 1, the counter and the latch are held clear and the counter does not advance. Counting resumes on the first enabled edge after masterRst returns to 0.
- R8: With autoRstDis=0, a low pulse on porN clears the timing, and counting starts on the first enabled edge after porN returns high.
- R9: With autoRstDis=1 during the porN pulse, the counter does not advance until masterRst has been driven high and then returned low.
- R10: A change of the select pins mid-count acts on the current count without clearing it or generating a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset pulse, active low |
| autoRstDis | input | 1 | 1 = power-on pulse does not start timing |
| masterRst | input | 1 | Synchronous master reset, active high |
| cntEn | input | 1 | Count-enable strobe |
| selA | input | 1 | Tap select, high bit |
| selB | input | 1 | Tap select, low bit |
| recycle | input | 1 | 1 = square wave, 0 = single transition |
| polInv | input | 1 | 1 = inverted output |
| timerOut | output | 1 | Timer output |

## Verification
The count register changes on the rising edge that completes an enabled count. The output is derived combinationally from the count and the latch, so it reflects the k-th count in the same cycle, one edge after the stimulus. Select, mode and polarity changes reach the output with no edge at all.

Clearing the latch on leaving single-transition mode takes one edge. Master reset and power-on clearing also take effect on the edge that samples them. The bench drives inputs on falling edges and samples on the following falling edge, after exactly one rising edge. Its expected values are computed from the number of enabled counts since the last reset.

// File: rtl/stage_timer_pkg.sv
package stage_timer_pkg;
  typedef struct packed {
    logic clear;    // synchronous clear of count and latch
    logic advance;  // increment count this edge
  } ctlStrb_t;
endpackage

// File: rtl/stage_timer_dp.sv
module stage_timer_dp
  import stage_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TAP_LL = 13,
  parameter int TAP_LH = 10,
  parameter int TAP_HL = 8,
  parameter int TAP_HH = 16
) (
  input  logic     clk,
  input  logic     porN,
  input  ctlStrb_t strb,
  input  logic     selA,
  input  logic     selB,
  output logic     stageBit
);
  localparam int NUM_TAPS = 4;
  localparam int TAPS [NUM_TAPS] = '{TAP_LL, TAP_LH, TAP_HL, TAP_HH};

  logic [CNT_W-1:0]    count;
  logic [NUM_TAPS-1:0] tapBits;

  always_ff @(posedge clk) begin
    if (strb.clear)        count <= '0;
    else if (strb.advance) count <= count + 1'b1;
  end

  for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
    assign tapBits[gi] = count[TAPS[gi]-1];
  end

  assign stageBit = tapBits[{selA, selB}];

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!porN)
    strb.clear |=> count == '0);
  // R1
  advance_step_chk: assert property (@(posedge clk) disable iff (!porN)
    strb.advance |=> count == $past(count) + CNT_W'(1));
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    (!strb.advance && !strb.clear) |=> $stable(count));
endmodule

// File: rtl/stage_timer_ctl.sv
module stage_timer_ctl
  import stage_timer_pkg::*;
(
  input  logic     clk,
  input  logic     porN,
  input  logic     autoRstDis,
  input  logic     masterRst,
  input  logic     cntEn,
  input  logic     recycle,
  input  logic     stageBit,
  output ctlStrb_t strb,
  output logic     levelOut
);
  logic runOk;
  logic latched;

  always_comb begin
    strb.clear   = !porN || masterRst;
    strb.advance = !strb.clear && runOk && cntEn;
  end

  always_ff @(posedge clk) begin
    if (!porN)          runOk <= !autoRstDis;
    else if (masterRst) runOk <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.clear || recycle) latched <= 1'b0;
    else if (stageBit)         latched <= 1'b1;
  end

  assign levelOut = recycle ? stageBit : (stageBit | latched);

  // R9
  run_after_pulse_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(masterRst) |-> runOk);
  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    (!recycle && levelOut && !strb.clear) |=> (levelOut || recycle));
  // R5
  latch_drop_chk: assert property (@(posedge clk) disable iff (!porN)
    recycle |=> !latched);
endmodule

// File: rtl/stage_timer.sv
module stage_timer
  import stage_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TAP_LL = 13,
  parameter int TAP_LH = 10,
  parameter int TAP_HL = 8,
  parameter int TAP_HH = 16
) (
  input  logic clk,
  input  logic porN,
  input  logic autoRstDis,
  input  logic masterRst,
  input  logic cntEn,
  input  logic selA,
  input  logic selB,
  input  logic recycle,
  input  logic polInv,
  output logic timerOut
);
  ctlStrb_t strb;
  logic     stageBit;
  logic     levelOut;

  stage_timer_ctl u_ctl (
    .clk(clk), .porN(porN), .autoRstDis(autoRstDis), .masterRst(masterRst),
    .cntEn(cntEn), .recycle(recycle), .stageBit(stageBit),
    .strb(strb), .levelOut(levelOut)
  );

  stage_timer_dp #(
    .CNT_W(CNT_W), .TAP_LL(TAP_LL), .TAP_LH(TAP_LH),
    .TAP_HL(TAP_HL), .TAP_HH(TAP_HH)
  ) u_dp (
    .clk(clk), .porN(porN), .strb(strb), .selA(selA), .selB(selB),
    .stageBit(stageBit)
  );

  assign timerOut = levelOut ^ polInv;

  // R6
  pol_apply_chk: assert property (@(posedge clk) disable iff (!porN)
    $changed(polInv) && $stable(levelOut) |-> $changed(timerOut));
endmodule

// File: tb/stage_timer_tb.sv
module stage_timer_tb;
  localparam int W = 6;
  localparam int T_LL = 5, T_LH = 3, T_HL = 2, T_HH = 6;

  logic clk = 1'b0;
  logic porN = 1'b0, autoRstDis = 1'b0, masterRst = 1'b0, cntEn = 1'b0;
  logic selA = 1'b0, selB = 1'b0, recycle = 1'b0, polInv = 1'b0;
  logic timerOut;
  int total = 0, bad = 0;
  int e;
  bit finished = 0;

  always #10 clk = ~clk;

  stage_timer #(.CNT_W(W), .TAP_LL(T_LL), .TAP_LH(T_LH), .TAP_HL(T_HL), .TAP_HH(T_HH))
  u_dut (.clk(clk), .porN(porN), .autoRstDis(autoRstDis), .masterRst(masterRst),
         .cntEn(cntEn), .selA(selA), .selB(selB), .recycle(recycle),
         .polInv(polInv), .timerOut(timerOut));

  function automatic int tapOf(input int sel);
    case (sel)
      0: return T_LL;
      1: return T_LH;
      2: return T_HL;
      default: return T_HH;
    endcase
  endfunction

  function automatic logic expOut(input int n, input int cnt, input logic rec, input logic pol);
    logic b;
    if (rec) b = (((cnt % (1 << W)) >> (n - 1)) & 1) != 0;
    else     b = cnt >= (1 << (n - 1));
    return b ^ pol;
  endfunction

  task automatic check(input logic exp, input string req);
    total++;
    if (timerOut !== exp) begin
      bad++;
      $display("FAIL %s: timerOut=%b expected=%b (count=%0d)", req, timerOut, exp, e);
    end
  endtask

  task automatic tick(input logic en);
    cntEn = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    masterRst = 1'b1;
    tick(1'b1);
    masterRst = 1'b0;
    e = 0;
  endtask

  task automatic powerUp(input logic dis);
    porN = 1'b0;
    autoRstDis = dis;
    tick(1'b0);
    tick(1'b0);
    porN = 1'b1;
    e = 0;
  endtask

  task automatic setSel(input int sel);
    selA = sel[1];
    selB = sel[0];
  endtask

  initial begin
    @(negedge clk);
    // R8: power-on with auto reset enabled, single mode, N=6
    setSel(3); recycle = 1'b0; polInv = 1'b0;
    powerUp(1'b0);
    check(1'b0, "R6 reset state");
    for (int k = 0; k < 34; k++) begin
      tick(1'b1); e++;
      check(expOut(T_HH, e, 1'b0, 1'b0), "R8 R4 power-on count");
    end

    // R9: auto reset disabled, no counting until master reset pulse
    setSel(2); recycle = 1'b1;
    powerUp(1'b1);
    for (int k = 0; k < 20; k++) begin
      tick(1'b1);
      check(1'b0, "R9 blocked before master reset");
    end
    doReset();
    tick(1'b1); e++;
    tick(1'b1); e++;
    check(expOut(T_HL, e, 1'b1, 1'b0), "R9 counting after master reset");

    // R1 R2 R3 R4 R6: sweep selects, polarities and modes with gapped enable
    for (int sel = 0; sel < 4; sel++)
      for (int pol = 0; pol < 2; pol++)
        for (int rec = 0; rec < 2; rec++) begin
          setSel(sel); polInv = pol[0]; recycle = rec[0];
          doReset();
          check(logic'(pol[0]), "R6 output after reset");
          for (int k = 0; k < (1 << W) + 24; k++) begin
            logic en;
            en = (k % 3) != 2;
            tick(en);
            if (en) e++;
            check(expOut(tapOf(sel), e, rec[0], pol[0]), "R1 R2 R3 R4 sweep");
          end
        end

    // R5: leaving single mode clears the latch
    setSel(2); polInv = 1'b0; recycle = 1'b0;
    doReset();
    for (int k = 0; k < 5; k++) begin tick(1'b1); e++; end
    check(1'b1, "R4 latched with stage bit low");
    recycle = 1'b1; tick(1'b0);
    check(1'b0, "R5 recycle shows stage bit");
    recycle = 1'b0; tick(1'b0);
    check(1'b0, "R5 latch cleared");

    // R7: master reset held high blocks counting
    recycle = 1'b1;
    doReset();
    for (int k = 0; k < 3; k++) begin tick(1'b1); e++; end
    check(1'b1, "R7 pre-reset count 3");
    masterRst = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick(1'b1);
      check(1'b0, "R7 held in reset");
    end
    masterRst = 1'b0; e = 0;
    tick(1'b1); e++;
    check(1'b0, "R7 first count after release");
    tick(1'b1); e++;
    check(1'b1, "R7 second count after release");

    // R10: select change mid-count keeps the count
    setSel(3); recycle = 1'b1;
    doReset();
    for (int k = 0; k < 20; k++) begin tick(1'b1); e++; end
    check(expOut(T_HH, e, 1'b1, 1'b0), "R10 before select change");
    setSel(1); tick(1'b0);
    check(expOut(T_LH, e, 1'b1, 1'b0), "R10 new tap same count");
    for (int k = 0; k < 6; k++) begin
      tick(1'b1); e++;
      check(expOut(T_LH, e, 1'b1, 1'b0), "R10 counting on new tap");
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule